// File: doc/BRIEF.md
# Masked Content-Addressable Memory with Lowest-Row Priority

This block is a word-organised store that can be searched by content as well as addressed like an ordinary memory. Each cycle it accepts one of four commands: idle, addressed read, addressed write, or search. A search compares a held search pattern against every stored word in the same cycle. A held bit-enable mask limits the comparison to chosen bit positions.

The search produces one flag per row. A priority encoder reduces the flags to a single winning row index and a found indication. When several rows agree with the pattern, the one with the smallest index wins. Every row carries an occupancy bit, so rows that have never been written take no part in a search. The search pattern and the mask each have their own load port, and loads can happen alongside any command.

All results are registered and appear one clock after the command. Each result holds its value until the next command of the kind that produces it.

Top module: `cam_masked_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hit_o`, `hit_addr_o`, `row_flags_o` and `rdata_o` are all zero, and every row is unoccupied.
- R2: `cmd_i` is encoded as 0 idle, 1 read, 2 write, 3 search. A write stores `wdata_i` at `addr_i` and marks that row occupied. A read of an occupied row returns its word on `rdata_o` one cycle later. A read of an unoccupied row returns zero.
- R3: In a search, bit r of `row_flags_o` is 1 exactly when row r is occupied and equals the pattern on every bit position where the mask holds a 1. Mask bits that are 0 are ignored.
- R4: A row that has never been written since reset never sets its flag, even when its stored bits would agree with the pattern.
- R5: When several rows match, `hit_addr_o` is the lowest-numbered matching row.
- R6: `hit_o` is 1 exactly when at least one flag is set. When no row matches, `hit_o` is 0 and `hit_addr_o` is 0.
- R7: With an all-zero mask, every occupied row matches, and `hit_addr_o` is the lowest occupied row.
- R8: Search results (`row_flags_o`, `hit_o`, `hit_addr_o`) update only in the cycle after a search command. `rdata_o` updates only in the cycle after a read. Other commands leave these outputs unchanged.
- R9: A pattern load (`cmp_load_i`), a mask load (`msk_load_i`) or a write takes effect for searches issued in later cycles. A search issued in the same cycle as a load uses the previously held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 0 idle, 1 read, 2 write, 3 search |
| addr_i | input | 9 | Row address for read and write |
| wdata_i | input | 64 | Write data |
| cmp_load_i | input | 1 | Load `cmp_i` into the search pattern register |
| cmp_i | input | 64 | New search pattern |
| msk_load_i | input | 1 | Load `msk_i` into the mask register |
| msk_i | input | 64 | New mask, 1 = bit takes part in the comparison |
| rdata_o | output | 64 | Read result |
| hit_o | output | 1 | At least one row matched in the last search |
| hit_addr_o | output | 9 | Lowest matching row, 0 when none |
| row_flags_o | output | 512 | Per-row match flags from the last search |

## Verification
Directed searches with a full mask, a partial mask and an all-zero mask show whether bits outside the mask are really ignored, and whether occupancy rather than stored content decides which rows can match. Duplicate words written at several addresses separate a lowest-index encoder from a highest-index or arbitrary one. A pattern held in rows that were never written separates occupancy gating from a plain content compare. Loads issued in the same cycle as a search show whether the old or the new pattern is used. Random fills drawn from a small set of values, searched with random masks, produce many multi-row ties and some empty results. Each of those searches is compared as a whole flag vector against a reference model in the bench.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_MATCH = 2'd3
    } cam_cmd_e;

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int WORDS = 512,
    parameter int WIDTH = 64,
    localparam int AW = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [AW-1:0]                waddr_i,
    input  logic [WIDTH-1:0]             wdata_i,
    output logic [WORDS-1:0][WIDTH-1:0]  rows_o,
    output logic [WORDS-1:0]             occ_o
);

    logic [WORDS-1:0][WIDTH-1:0] rows_d, rows_q;
    logic [WORDS-1:0]            occ_d, occ_q;

    // Next-state: one addressed row and its occupancy bit change on a write.
    always_comb begin
        rows_d = rows_q;
        occ_d  = occ_q;
        if (we_i) begin
            rows_d[waddr_i] = wdata_i;
            occ_d[waddr_i]  = 1'b1;
        end
    end

    // Occupancy is cleared by reset; stored words need no reset because
    // an unoccupied row is never visible through a read or a search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
        rows_q <= rows_d;
    end

    assign rows_o = rows_q;
    assign occ_o  = occ_q;

endmodule

// File: rtl/cam_row_match.sv
module cam_row_match #(
    parameter int WORDS = 512,
    parameter int WIDTH = 64
) (
    input  logic [WORDS-1:0][WIDTH-1:0] rows_i,
    input  logic [WORDS-1:0]            occ_i,
    input  logic [WIDTH-1:0]            cmp_i,
    input  logic [WIDTH-1:0]            msk_i,
    output logic [WORDS-1:0]            flags_o
);

    // One comparator per row, all evaluated in parallel.
    for (genvar r = 0; r < WORDS; r++) begin : g_row
        logic [WIDTH-1:0] diff;
        assign diff       = (rows_i[r] ^ cmp_i) & msk_i;
        assign flags_o[r] = occ_i[r] & ~(|diff);
    end

endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N = 512,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  flags_i,
    output logic [AW-1:0] idx_o,
    output logic          any_o
);

    // Scan from the top down so the lowest set index is the last to assign.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags_i[i]) begin
                idx_o = AW'(i);
            end
        end
        any_o = |flags_i;
    end

endmodule

// File: rtl/cam_masked_top.sv
module cam_masked_top #(
    parameter int WORDS = 512,
    parameter int WIDTH = 64,
    localparam int AW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             cmp_load_i,
    input  logic [WIDTH-1:0] cmp_i,
    input  logic             msk_load_i,
    input  logic [WIDTH-1:0] msk_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             hit_o,
    output logic [AW-1:0]    hit_addr_o,
    output logic [WORDS-1:0] row_flags_o
);

    import cam_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] cmp;
        logic [WIDTH-1:0] msk;
        logic [WIDTH-1:0] rdata;
        logic             hit;
        logic [AW-1:0]    hit_addr;
        logic [WORDS-1:0] flags;
    } cam_state_t;

    cam_state_t state_d, state_q;
    cam_cmd_e   cmd;

    logic [WORDS-1:0][WIDTH-1:0] rows;
    logic [WORDS-1:0]            occ;
    logic [WORDS-1:0]            flags_now;
    logic [AW-1:0]               win_idx;
    logic                        win_any;

    assign cmd = cam_cmd_e'(cmd_i);

    cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cmd == CMD_WRITE),
        .waddr_i (addr_i),
        .wdata_i (wdata_i),
        .rows_o  (rows),
        .occ_o   (occ)
    );

    // Searches use the pattern and mask held before this edge.
    cam_row_match #(.WORDS(WORDS), .WIDTH(WIDTH)) match_i (
        .rows_i  (rows),
        .occ_i   (occ),
        .cmp_i   (state_q.cmp),
        .msk_i   (state_q.msk),
        .flags_o (flags_now)
    );

    cam_prio_enc #(.N(WORDS)) enc_i (
        .flags_i (flags_now),
        .idx_o   (win_idx),
        .any_o   (win_any)
    );

    always_comb begin
        state_d = state_q;
        if (cmp_load_i) begin
            state_d.cmp = cmp_i;
        end
        if (msk_load_i) begin
            state_d.msk = msk_i;
        end
        unique case (cmd)
            CMD_READ: begin
                state_d.rdata = occ[addr_i] ? rows[addr_i] : '0;
            end
            CMD_MATCH: begin
                state_d.flags    = flags_now;
                state_d.hit      = win_any;
                state_d.hit_addr = win_idx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o     = state_q.rdata;
    assign hit_o       = state_q.hit;
    assign hit_addr_o  = state_q.hit_addr;
    assign row_flags_o = state_q.flags;

endmodule

// File: rtl/cam_masked_chk.sv
module cam_masked_chk #(
    parameter int WORDS = 512,
    parameter int WIDTH = 64,
    localparam int AW = $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd_i,
    input logic [WIDTH-1:0] rdata_o,
    input logic             hit_o,
    input logic [AW-1:0]    hit_addr_o,
    input logic [WORDS-1:0] row_flags_o
);

    // Found indication agrees with the flag vector (encoder vs flag register).
    assert_hit_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == (|row_flags_o));

    // Empty result reports row zero.
    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (hit_addr_o == '0));

    // The reported row is itself flagged.
    assert_winner_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> row_flags_o[hit_addr_o]);

    // No flagged row lies below the winner.
    assert_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((row_flags_o & ((WORDS'(1) << hit_addr_o) - WORDS'(1))) == '0));

    // Search results hold across non-search commands.
    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != 2'd3) |=> ($stable(row_flags_o) && $stable(hit_o) && $stable(hit_addr_o)));

    // Read data holds across non-read commands.
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != 2'd1) |=> $stable(rdata_o));

endmodule

bind cam_masked_top cam_masked_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .rdata_o     (rdata_o),
    .hit_o       (hit_o),
    .hit_addr_o  (hit_addr_o),
    .row_flags_o (row_flags_o)
);

// File: tb/cam_masked_top_tb.sv
module cam_masked_top_tb_top;

    localparam int WORDS = 512;
    localparam int WIDTH = 64;
    localparam int AW    = 9;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       cmd_i;
    logic [AW-1:0]    addr_i;
    logic [WIDTH-1:0] wdata_i;
    logic             cmp_load_i;
    logic [WIDTH-1:0] cmp_i;
    logic             msk_load_i;
    logic [WIDTH-1:0] msk_i;
    logic [WIDTH-1:0] rdata_o;
    logic             hit_o;
    logic [AW-1:0]    hit_addr_o;
    logic [WORDS-1:0] row_flags_o;

    always #10 clk = ~clk;

    cam_masked_top #(.WORDS(WORDS), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .cmp_load_i(cmp_load_i), .cmp_i(cmp_i), .msk_load_i(msk_load_i), .msk_i(msk_i),
        .rdata_o(rdata_o), .hit_o(hit_o), .hit_addr_o(hit_addr_o), .row_flags_o(row_flags_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [WIDTH-1:0] mem_m [WORDS];
    logic             occ_m [WORDS];
    logic [WIDTH-1:0] cmp_m, msk_m;

    task automatic check(input string req, input logic [WORDS-1:0] act,
                         input logic [WORDS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [WORDS-1:0] model_flags();
        logic [WORDS-1:0] f = '0;
        for (int r = 0; r < WORDS; r++)
            f[r] = occ_m[r] && (((mem_m[r] ^ cmp_m) & msk_m) == '0);
        return f;
    endfunction

    function automatic logic [AW-1:0] model_win(input logic [WORDS-1:0] f);
        for (int r = 0; r < WORDS; r++)
            if (f[r]) return AW'(r);
        return '0;
    endfunction

    // One command: driven at a falling edge, result visible at the next one.
    task automatic run(input logic [1:0] c, input int a, input logic [WIDTH-1:0] d);
        cmd_i = c; addr_i = AW'(a); wdata_i = d;
        @(negedge clk);
        cmd_i = 2'd0; cmp_load_i = 0; msk_load_i = 0;
        if (c == 2'd2) begin
            mem_m[a] = d; occ_m[a] = 1'b1;
        end
    endtask

    task automatic set_pat(input logic [WIDTH-1:0] c, input logic [WIDTH-1:0] m);
        cmp_i = c; msk_i = m; cmp_load_i = 1; msk_load_i = 1;
        run(2'd0, 0, '0);
        cmp_m = c; msk_m = m;
    endtask

    task automatic search_check(input string req);
        logic [WORDS-1:0] f;
        run(2'd3, 0, '0);
        f = model_flags();
        check({req, " flags"}, row_flags_o, f);
        check({req, " hit"}, WORDS'(hit_o), WORDS'(|f));
        check({req, " addr"}, WORDS'(hit_addr_o), WORDS'(model_win(f)));
    endtask

    task automatic read_check(input string req, input int a);
        run(2'd1, a, '0);
        check(req, WORDS'(rdata_o), WORDS'(occ_m[a] ? mem_m[a] : '0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [WIDTH-1:0] pool [4];
        logic [WORDS-1:0] keep;
        int unsigned      s;
        s = $urandom(32'h5EED_0C4A);
        for (int r = 0; r < WORDS; r++) begin mem_m[r] = '0; occ_m[r] = 0; end
        cmp_m = '0; msk_m = '0;
        rst_n = 0; cmd_i = 0; addr_i = 0; wdata_i = 0;
        cmp_load_i = 0; cmp_i = 0; msk_load_i = 0; msk_i = 0;
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        check("R1 flags in reset", row_flags_o, '0);
        check("R1 hit/addr/rdata in reset", WORDS'({hit_o, hit_addr_o, rdata_o}), '0);
        rst_n = 1;
        @(negedge clk);
        check("R1 outputs after reset", WORDS'({hit_o, hit_addr_o, rdata_o}), '0);

        // R4 and R1: all rows empty, a zero pattern with full mask matches nothing
        set_pat('0, '1);
        search_check("R4 empty array");
        read_check("R2 read unoccupied", 5);

        // R2: write/read
        run(2'd2, 7, 64'hDEAD_BEEF_0123_4567);
        read_check("R2 read back", 7);
        run(2'd2, 511, 64'hFFFF_0000_FFFF_0000);
        read_check("R2 read top row", 511);

        // R5: duplicates, lowest wins
        run(2'd2, 300, 64'hA5A5);
        run(2'd2, 40, 64'hA5A5);
        run(2'd2, 200, 64'hA5A5);
        set_pat(64'hA5A5, '1);
        search_check("R5 lowest of duplicates");
        check("R5 winner row 40", WORDS'(hit_addr_o), WORDS'(40));

        // R3: partial mask ignores low byte
        run(2'd2, 12, 64'hA5FF);
        set_pat(64'hA500, 64'hFF00);
        search_check("R3 partial mask");
        check("R3 row 12 wins", WORDS'(hit_addr_o), WORDS'(12));

        // R6: no match
        set_pat(64'h1234_5678_9ABC_DEF0, '1);
        search_check("R6 no match");
        check("R6 addr zero on miss", WORDS'({hit_o, hit_addr_o}), '0);

        // R7: empty mask matches every occupied row
        set_pat(64'h1234, '0);
        search_check("R7 zero mask");
        check("R7 lowest occupied", WORDS'(hit_addr_o), WORDS'(7));

        // R8: non-search commands hold results; write does not disturb them
        keep = row_flags_o;
        run(2'd2, 0, 64'h77);
        run(2'd1, 0, '0);
        check("R8 flags held", row_flags_o, keep);
        check("R8 addr held", WORDS'(hit_addr_o), WORDS'(7));
        run(2'd3, 0, '0);
        check("R9 write visible next search", WORDS'(hit_addr_o), WORDS'(0));

        // R9: search issued with a load uses the old pattern
        set_pat(64'h77, '1);
        cmp_i = 64'hA5A5; cmp_load_i = 1;
        run(2'd3, 0, '0);
        check("R9 same-cycle load uses old pattern", WORDS'({hit_o, hit_addr_o}), WORDS'({1'b1, 9'd0}));
        cmp_m = 64'hA5A5;
        search_check("R9 new pattern next search");
        check("R9 new winner row 40", WORDS'(hit_addr_o), WORDS'(40));
        read_check("R8 rdata updates on read", 0);

        // Random fill and search
        pool[0] = 64'h0F0F_0000_1111_2222; pool[1] = 64'h0F0F_0000_1111_2223;
        pool[2] = 64'hF0F0_AAAA_0000_0001; pool[3] = 64'h0000_0000_0000_0000;
        for (int k = 0; k < 120; k++)
            run(2'd2, int'($urandom_range(WORDS - 1)), pool[$urandom_range(3)]);
        for (int k = 0; k < 40; k++) begin
            set_pat(pool[$urandom_range(3)], {$urandom, $urandom});
            search_check("R3 random search");
        end
        for (int k = 0; k < 20; k++)
            read_check("R2 random read", int'($urandom_range(WORDS - 1)));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule